// File: doc/BRIEF.md
# Chained Queue Select and Output Valid

This block sits at the address front end of one multi-queue device that shares its write and read address buses with up to seven other devices in a chain. At master reset it captures a 3-bit device identity and a master/slave strap. After that, each write or read selection strobe compares the top three address bits with the captured identity. On a match, the remaining low bits name the local queue.

The block also decides whether this device may drive the shared data output and the shared output-valid line. A master owns both lines from reset onward. A slave owns them only after a read selection has addressed it. Any read selection that addresses another device takes ownership away.

The output-valid flag is active low. It is pipelined so that it changes two clock edges after the selection, which matches the delay of the data path. It also goes invalid when the selected queue reports empty.

Top module: `chain_qsel`

## Requirements
- R1: On any clock edge where `mrst_n` is low, the block clears its selection state. After that edge, `wr_hit`=0, `rd_hit`=0, `wr_queue`=0, `rd_queue`=0 and `ov_n`=1.
- R2: `id_strap` and `master_strap` are captured only on edges where `mrst_n` is low. Changing them while `mrst_n` is high has no effect on address matching or on ownership.
- R3: On an edge with `wr_sel`=1, `wr_hit` becomes 1 and `wr_queue` becomes `wr_addr[1:0]` if `wr_addr[4:2]` equals the captured ID. Otherwise `wr_hit` becomes 0 and `wr_queue` becomes 0. With `wr_sel`=0, both hold their values.
- R4: On an edge with `rd_sel`=1, `rd_hit` becomes 1 and `rd_queue` becomes `rd_addr[2:0]` if two conditions both hold: `rd_addr[5:3]` equals the captured ID, and `rd_addr[2:0]` is below the queue count (4). Otherwise `rd_hit` becomes 0 and `rd_queue` becomes 0.
- R5: After a reset with `master_strap`=1, the device owns the outputs: `data_oe` = NOT `oe_n`. After a reset with `master_strap`=0, `data_oe`=0 until a read hit.
- R6: While the device owns the outputs, `data_oe` follows `oe_n` (active low) combinationally, with no clock edge needed.
- R7: A read selection that is not a hit clears ownership. After that edge, `data_oe`=0 and `ov_oe`=0 whatever the state of `oe_n`.
- R8: After a read hit on queue q at edge E, `ov_n` equals NOT(NOT `q_empty[q]`) after edge E+2. A non-hit gives `ov_n`=1 after E+2.
- R9: If `q_empty` of the selected queue goes high before edge K, `ov_n` is still 0 after K and is 1 after edge K+1.
- R10: `ov_oe` is 1 exactly when the device owns the outputs (the same ownership as R5 and R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| id_strap | input | 3 | Device identity strap, captured in reset |
| master_strap | input | 1 | 1 = master device, captured in reset |
| wr_sel | input | 1 | Write queue-select strobe |
| wr_addr | input | 5 | Write address: [4:2] device, [1:0] queue |
| rd_sel | input | 1 | Read queue-select strobe |
| rd_addr | input | 6 | Read address: [5:3] device, [2:0] queue |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| q_empty | input | 4 | Per-queue empty status, bit i = queue i |
| wr_hit | output | 1 | Last write selection addressed this device |
| wr_queue | output | 2 | Selected local write queue |
| rd_hit | output | 1 | Last read selection addressed this device |
| rd_queue | output | 3 | Selected local read queue |
| data_oe | output | 1 | Drive enable for the shared data output |
| ov_n | output | 1 | Output valid, active low |
| ov_oe | output | 1 | Drive enable for the shared output-valid line |

## Verification
A corrupted captured identity shows up at the first selection that follows. `rd_hit` or `wr_hit` takes the wrong value one edge after the strobe, and ownership flips at the same time: `data_oe` and `ov_oe` change at once.

A fault in the valid pipeline stays hidden until two edges after a selection or an empty change. The bench therefore samples `ov_n` exactly at those edges, and also one edge early, so that a pipeline that is too short or too long fails.

A wrong ownership register is visible straight away through `data_oe`, because `oe_n` reaches the port through logic alone.

// File: rtl/cqs_pkg.sv
package cqs_pkg;
    localparam int ID_W = 3;

    // Straps captured while master reset is asserted
    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            master;
    } strap_t;

    function automatic logic dev_match(input logic [ID_W-1:0] upper,
                                       input logic [ID_W-1:0] dev_id);
        return upper == dev_id;
    endfunction
endpackage

// File: rtl/cqs_addr_decode.sv
module cqs_addr_decode
    import cqs_pkg::*;
#(
    parameter int AW = 5,
    parameter int NQ = 4
) (
    input  logic                 clk,
    input  logic                 mrst_n,
    input  logic                 sel,
    input  logic [AW-1:0]        addr,
    input  logic [ID_W-1:0]      dev_id,
    output logic                 hit_d,
    output logic                 hit,
    output logic [AW-ID_W-1:0]   queue
);
    localparam int LW = AW - ID_W;

    logic [LW-1:0] low;
    logic          in_range;

    assign low = addr[LW-1:0];

    generate
        if ((2 ** LW) > NQ) begin : g_range
            assign in_range = (int'(low) < NQ);
        end else begin : g_full
            assign in_range = 1'b1;
        end
    endgenerate

    assign hit_d = sel && dev_match(addr[AW-1 -: ID_W], dev_id) && in_range;

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            hit   <= 1'b0;
            queue <= '0;
        end else if (sel) begin
            hit   <= hit_d;
            queue <= hit_d ? low : '0;
        end
    end

    // R3/R4: a strobe that matches loads the low bits on the next edge
    a_r3_sel_loads: assert property (@(posedge clk) disable iff (!mrst_n)
        sel && dev_match(addr[AW-1 -: ID_W], dev_id) && (int'(low) < NQ)
        |=> hit && queue == $past(low));

    // R4: a strobe that misses clears the hit on the next edge
    a_r4_sel_miss: assert property (@(posedge clk) disable iff (!mrst_n)
        sel && !dev_match(addr[AW-1 -: ID_W], dev_id) |=> !hit && queue == '0);

    // R3: without a strobe the selection holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!mrst_n)
        !sel && $past(mrst_n) |=> $stable(hit) && $stable(queue));
endmodule

// File: rtl/cqs_ov_pipe.sv
module cqs_ov_pipe #(
    parameter int NQ = 4,
    parameter int QW = 3
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          sel_hit,
    input  logic [QW-1:0] queue,
    input  logic [NQ-1:0] q_empty,
    output logic          ov_n
);
    logic q_is_empty;
    logic valid_s0;
    logic valid_s1;

    always_comb begin
        q_is_empty = 1'b1;
        for (int i = 0; i < NQ; i++) begin
            if (int'(queue) == i) q_is_empty = q_empty[i];
        end
    end

    assign valid_s0 = sel_hit && !q_is_empty;

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            valid_s1 <= 1'b0;
            ov_n     <= 1'b1;
        end else begin
            valid_s1 <= valid_s0;
            ov_n     <= !valid_s1;
        end
    end

    // R8/R9: the flag reflects the selected queue state from two edges back
    a_r8_two_stage: assert property (@(posedge clk) disable iff (!mrst_n)
        $past(mrst_n) && $past(mrst_n, 2) |-> ov_n == !$past(valid_s0, 2));
endmodule

// File: rtl/chain_qsel.sv
module chain_qsel
    import cqs_pkg::*;
#(
    parameter int NQ   = 4,
    parameter int WA_W = 5,
    parameter int RA_W = 6
) (
    input  logic                   clk,
    input  logic                   mrst_n,
    input  logic [ID_W-1:0]        id_strap,
    input  logic                   master_strap,
    input  logic                   wr_sel,
    input  logic [WA_W-1:0]        wr_addr,
    input  logic                   rd_sel,
    input  logic [RA_W-1:0]        rd_addr,
    input  logic                   oe_n,
    input  logic [NQ-1:0]          q_empty,
    output logic                   wr_hit,
    output logic [WA_W-ID_W-1:0]   wr_queue,
    output logic                   rd_hit,
    output logic [RA_W-ID_W-1:0]   rd_queue,
    output logic                   data_oe,
    output logic                   ov_n,
    output logic                   ov_oe
);
    localparam int RQ_W = RA_W - ID_W;

    strap_t cfg;
    logic   owner;
    logic   wr_hit_d;
    logic   rd_hit_d;

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            cfg   <= '{id: id_strap, master: master_strap};
            owner <= master_strap;
        end else if (rd_sel) begin
            owner <= rd_hit_d;
        end
    end

    cqs_addr_decode #(.AW(WA_W), .NQ(NQ)) i_wr_dec (
        .clk(clk), .mrst_n(mrst_n), .sel(wr_sel), .addr(wr_addr),
        .dev_id(cfg.id), .hit_d(wr_hit_d), .hit(wr_hit), .queue(wr_queue)
    );

    cqs_addr_decode #(.AW(RA_W), .NQ(NQ)) i_rd_dec (
        .clk(clk), .mrst_n(mrst_n), .sel(rd_sel), .addr(rd_addr),
        .dev_id(cfg.id), .hit_d(rd_hit_d), .hit(rd_hit), .queue(rd_queue)
    );

    cqs_ov_pipe #(.NQ(NQ), .QW(RQ_W)) i_ov (
        .clk(clk), .mrst_n(mrst_n), .sel_hit(rd_hit), .queue(rd_queue),
        .q_empty(q_empty), .ov_n(ov_n)
    );

    assign data_oe = owner && !oe_n;
    assign ov_oe   = owner;

    // R1: the first cycle out of reset shows a cleared selection
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!mrst_n)
        !$past(mrst_n) |-> ov_n && !rd_hit && !wr_hit);

    // R2: the captured straps never move outside reset
    a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(cfg));

    // R7: a read strobe for another device drops both drives
    a_r7_miss_release: assert property (@(posedge clk) disable iff (!mrst_n)
        rd_sel && rd_addr[RA_W-1 -: ID_W] != cfg.id |=> !data_oe && !ov_oe);

    // R5: reset hands ownership to the master only
    a_r5_master_owns: assert property (@(posedge clk) disable iff (!mrst_n)
        !$past(mrst_n) |-> ov_oe == $past(master_strap));
endmodule

// File: tb/test_chain_qsel.sv
module test_chain_qsel;
    logic       clk = 1'b0;
    logic       mrst_n = 1'b0;
    logic [2:0] id_strap = 3'b101;
    logic       master_strap = 1'b0;
    logic       wr_sel = 1'b0;
    logic [4:0] wr_addr = '0;
    logic       rd_sel = 1'b0;
    logic [5:0] rd_addr = '0;
    logic       oe_n = 1'b0;
    logic [3:0] q_empty = '0;
    logic       wr_hit, rd_hit, data_oe, ov_n, ov_oe;
    logic [1:0] wr_queue;
    logic [2:0] rd_queue;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    chain_qsel i_chain_qsel (
        .clk(clk), .mrst_n(mrst_n), .id_strap(id_strap), .master_strap(master_strap),
        .wr_sel(wr_sel), .wr_addr(wr_addr), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .oe_n(oe_n), .q_empty(q_empty), .wr_hit(wr_hit), .wr_queue(wr_queue),
        .rd_hit(rd_hit), .rd_queue(rd_queue), .data_oe(data_oe), .ov_n(ov_n),
        .ov_oe(ov_oe)
    );

    typedef struct packed {
        logic [5:0] addr;
        logic [3:0] empty;
        logic       hit;
        logic [2:0] q;
        logic       ovn;
    } vec_t;

    // Device ID is 3'b101 throughout the table
    localparam vec_t VECS [6] = '{
        '{6'b101010, 4'b0000, 1'b1, 3'd2, 1'b0},
        '{6'b101011, 4'b1000, 1'b1, 3'd3, 1'b1},
        '{6'b100001, 4'b0000, 1'b0, 3'd0, 1'b1},
        '{6'b101110, 4'b0000, 1'b0, 3'd0, 1'b1},
        '{6'b101000, 4'b1110, 1'b1, 3'd0, 1'b0},
        '{6'b001001, 4'b0000, 1'b0, 3'd0, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] id, input logic mast);
        mrst_n = 1'b0;
        id_strap = id;
        master_strap = mast;
        rd_sel = 1'b0;
        wr_sel = 1'b0;
        tick();
        tick();
        chk("R1 wr_hit", 8'(wr_hit), 8'd0);
        chk("R1 rd_hit", 8'(rd_hit), 8'd0);
        chk("R1 rd_queue", 8'(rd_queue), 8'd0);
        chk("R1 ov_n", 8'(ov_n), 8'd1);
        mrst_n = 1'b1;
    endtask

    task automatic rd_select(input logic [5:0] a);
        rd_addr = a;
        rd_sel = 1'b1;
        tick();
        rd_sel = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Slave device with ID 5
        do_reset(3'b101, 1'b0);
        chk("R5 slave data_oe", 8'(data_oe), 8'd0);
        chk("R10 slave ov_oe", 8'(ov_oe), 8'd0);
        // Change the pins after reset; must be ignored (R2)
        id_strap = 3'b000;
        master_strap = 1'b1;

        foreach (VECS[i]) begin
            q_empty = VECS[i].empty;
            rd_select(VECS[i].addr);
            chk("R4 rd_hit", 8'(rd_hit), 8'(VECS[i].hit));
            chk("R4 rd_queue", 8'(rd_queue), 8'(VECS[i].q));
            chk("R10 ov_oe", 8'(ov_oe), 8'(VECS[i].hit));
            tick();
            tick();
            chk("R8 ov_n", 8'(ov_n), 8'(VECS[i].ovn));
        end

        // R2: the new pin value must not match, the latched one must
        rd_select(6'b000001);
        chk("R2 new id ignored", 8'(rd_hit), 8'd0);
        rd_select(6'b101001);
        chk("R2 latched id", 8'(rd_hit), 8'd1);

        // R3: write decode
        wr_addr = 5'b10111;
        wr_sel = 1'b1;
        tick();
        chk("R3 wr_hit", 8'(wr_hit), 8'd1);
        chk("R3 wr_queue", 8'(wr_queue), 8'd3);
        wr_sel = 1'b0;
        wr_addr = 5'b01101;
        tick();
        chk("R3 hold", 8'(wr_queue), 8'd3);
        wr_sel = 1'b1;
        tick();
        chk("R3 miss", 8'(wr_hit), 8'd0);
        wr_sel = 1'b0;

        // R9: selected queue 1 goes empty
        q_empty = 4'b0000;
        rd_select(6'b101001);
        tick();
        tick();
        chk("R8 ov_n valid", 8'(ov_n), 8'd0);
        q_empty = 4'b0010;
        tick();
        chk("R9 ov_n after K", 8'(ov_n), 8'd0);
        tick();
        chk("R9 ov_n after K+1", 8'(ov_n), 8'd1);

        // R6: asynchronous output enable while owning
        oe_n = 1'b1;
        #1;
        chk("R6 oe high", 8'(data_oe), 8'd0);
        oe_n = 1'b0;
        #1;
        chk("R6 oe low", 8'(data_oe), 8'd1);
        chk("R10 owner ov_oe", 8'(ov_oe), 8'd1);

        // R7: selection for another device releases drives
        rd_select(6'b000000);
        chk("R7 data_oe", 8'(data_oe), 8'd0);
        chk("R7 ov_oe", 8'(ov_oe), 8'd0);

        // R5: master owns after reset
        do_reset(3'b010, 1'b1);
        chk("R5 master data_oe", 8'(data_oe), 8'd1);
        chk("R10 master ov_oe", 8'(ov_oe), 8'd1);
        master_strap = 1'b0;
        tick();
        chk("R2 master kept", 8'(ov_oe), 8'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule